// File: doc/BRIEF.md
# Fractional Reference Clock Divider

The block produces a reference clock from one of sixteen source tick inputs. Each source is a one-cycle enable pulse in the block's clock domain, and every pulse counts as one input period. The division ratio is an integer divisor plus a trim in 1/512 steps, so the output frequency is fin × 256 / (512 × div + trim). With a zero trim this reduces to fin / (2 × div). When both fields are zero, the selected input passes straight through.

Software programs the block through two 32-bit registers: a control word at offset 0x00 and a trim word at offset 0x10. Writes to the source, divisor and trim fields only stage the new values. They take effect together when software sets the switch bit. One cycle later, hardware copies the staged set into the live set, restarts the output phase low, and clears the switch bit.

A running flag shows that the generator is in use. While that flag is set, the staged source field does not change. The output pin is driven only when both the run bit and the pin-enable bit are set.

Top module: `refclk_frac_div`

## Requirements
- R1: After reset, both register reads return 0 and `ref_out` is low.
- R2: Control word fields are source [3:0], running flag [8] (read only), switch [9], pin enable [12], run [15] and divisor [30:16]. The trim word holds the trim in bits [31:23]. Reads return the staged values.
- R3: A control write with bit 9 set reads back with bit 9 set on the next cycle. Hardware then clears the bit one cycle later, and on that same edge the staged source, divisor and trim become live.
- R4: Staged divisor and trim have no effect on `ref_out` until a switch is performed.
- R5: With a live divisor d and trim t, and both not zero together, `ref_out` starts low after a switch. Half period k (k = 0, 1, …) lasts d + floor(k·t/512) − floor((k−1)·t/512) ticks of the selected source, where the fractional term is 0 for k = 0.
- R6: With live divisor and trim both zero, `ref_out` equals the selected source tick of the previous cycle.
- R7: Only ticks of the live source move `ref_out`.
- R8: `ref_out` stays low while the run bit or the pin-enable bit is clear. With the run bit clear, the generator is held at its start state.
- R9: The running flag is set one cycle after the run bit becomes set and clears one cycle after it becomes clear. A control write made while the flag is set leaves the staged source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | NSRC | One enable pulse per input period, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset: 0x00 control, 0x10 trim |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ref_out | output | 1 | Divided reference clock |

## Verification
Directed settings cover three cases: trim 0, which gives equal half periods; trim 511, where almost every half period is stretched; and divisor and trim both 0, the pass-through case. Each is checked half period by half period against the closed-form floor expression, which shows whether the fractional carry lands on the correct half period. Random source, divisor and trim settings are driven with random ticks on every source, so a wrong source decode shows up as a wrong half-period length. Further sequences check three things: a staged-but-unswitched divisor leaves the period unchanged; clearing the pin enable silences the pin; and a write made while running cannot move the source.

// File: rtl/refclk_pkg.sv
// Package: field positions and widths of the reference divider registers.
// Assumes 32-bit register words; positions are fixed by the software view.
package refclk_pkg;
    localparam int SEL_W   = 4;
    localparam int DIV_W   = 15;
    localparam int TRIM_W  = 9;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 32;

    localparam int SEL_LSB   = 0;
    localparam int ACT_BIT   = 8;
    localparam int SW_BIT    = 9;
    localparam int OE_BIT    = 12;
    localparam int RUN_BIT   = 15;
    localparam int DIV_LSB   = 16;
    localparam int TRIM_LSB  = 23;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h00;
    localparam logic [ADDR_W-1:0] TRIM_ADDR = 5'h10;
endpackage

// File: rtl/refclk_regs.sv
// Module: staged/live register set with self-clearing switch.
// Assumes one write per cycle; the switch copies staged fields to live
// on the cycle after it is set and clears itself on that same edge.
module refclk_regs
    import refclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              active,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [SEL_W-1:0]  sel_stage,
    output logic [SEL_W-1:0]  sel_live,
    output logic [DIV_W-1:0]  div_stage,
    output logic [DIV_W-1:0]  div_live,
    output logic [TRIM_W-1:0] trim_live,
    output logic              on_bit,
    output logic              oe_bit,
    output logic              sw_pend
);
    logic [TRIM_W-1:0] trim_stage;
    logic              wr_ctrl;
    logic              wr_trim;
    logic              unused_wbits;

    assign wr_ctrl = reg_wr && (reg_addr == CTRL_ADDR);
    assign wr_trim = reg_wr && (reg_addr == TRIM_ADDR);
    assign unused_wbits = ^{reg_wdata[31], reg_wdata[14:13], reg_wdata[11:10],
                            reg_wdata[8:4], reg_wdata[22:0]};

    // Register state: staged writes, atomic commit, switch self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_stage  <= '0;
            sel_live   <= '0;
            div_stage  <= '0;
            div_live   <= '0;
            trim_stage <= '0;
            trim_live  <= '0;
            on_bit     <= 1'b0;
            oe_bit     <= 1'b0;
            sw_pend    <= 1'b0;
        end else begin
            if (sw_pend) begin
                sw_pend   <= 1'b0;
                sel_live  <= sel_stage;
                div_live  <= div_stage;
                trim_live <= trim_stage;
            end
            if (wr_ctrl) begin
                on_bit    <= reg_wdata[RUN_BIT];
                oe_bit    <= reg_wdata[OE_BIT];
                div_stage <= reg_wdata[DIV_LSB +: DIV_W];
                if (!active)
                    sel_stage <= reg_wdata[SEL_LSB +: SEL_W];
                if (!sw_pend && reg_wdata[SW_BIT])
                    sw_pend <= 1'b1;
            end
            if (wr_trim)
                trim_stage <= reg_wdata[TRIM_LSB +: TRIM_W];
        end
    end

    // Read mux: staged view of the addressed word.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata[SEL_LSB +: SEL_W] = sel_stage;
            reg_rdata[ACT_BIT]          = active;
            reg_rdata[SW_BIT]           = sw_pend;
            reg_rdata[OE_BIT]           = oe_bit;
            reg_rdata[RUN_BIT]          = on_bit;
            reg_rdata[DIV_LSB +: DIV_W] = div_stage;
        end else if (reg_addr == TRIM_ADDR) begin
            reg_rdata[TRIM_LSB +: TRIM_W] = trim_stage;
        end
    end
endmodule

// File: rtl/refclk_phase.sv
// Module: fractional half-period generator.
// Each half period lasts div ticks plus one when the trim accumulator
// carries past 2^TRIM_W; div=trim=0 passes the tick through. A zero
// computed length is raised to one tick. Assumes tick is one cycle wide.
module refclk_phase
    import refclk_pkg::*;
#(
    parameter int CNT_W = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [DIV_W-1:0]  div,
    input  logic [TRIM_W-1:0] trim,
    output logic              clk_q,
    output logic              busy
);
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  half_raw;
    logic [CNT_W-1:0]  half_len;
    logic [TRIM_W-1:0] acc;
    logic              carry_q;
    logic [TRIM_W:0]   sum;
    logic              bypass;
    logic              edge_now;

    assign bypass   = (div == '0) && (trim == '0);
    assign half_raw = CNT_W'(div) + CNT_W'(carry_q);
    assign half_len = (half_raw == '0) ? CNT_W'(1) : half_raw;
    assign sum      = {1'b0, acc} + {1'b0, trim};
    assign edge_now = tick && ((cnt + CNT_W'(1)) >= half_len);

    // Phase state: tick count, trim accumulator, output level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt     <= '0;
            acc     <= '0;
            carry_q <= 1'b0;
            clk_q   <= 1'b0;
        end else if (bypass) begin
            clk_q <= tick;
        end else if (edge_now) begin
            cnt     <= '0;
            acc     <= sum[TRIM_W-1:0];
            carry_q <= sum[TRIM_W];
            clk_q   <= ~clk_q;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Running flag: follows the run bit one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= run;
    end
endmodule

// File: rtl/refclk_frac_div.sv
// Module: top of the fractional reference clock divider.
// Selects one source tick by the live source field, divides it and gates
// the result with the pin enable. Assumes source ticks are synchronous.
module refclk_frac_div
    import refclk_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ref_out
);
    localparam int PAD = (1 << SEL_W);

    logic [SEL_W-1:0]  sel_stage;
    logic [SEL_W-1:0]  sel_live;
    logic [DIV_W-1:0]  div_stage;
    logic [DIV_W-1:0]  div_live;
    logic [TRIM_W-1:0] trim_live;
    logic              on_bit;
    logic              oe_bit;
    logic              sw_pend;
    logic              active;
    logic              gen_q;
    logic [PAD-1:0]    tick_vec;
    logic              tick_sel;

    // Widen the source vector so every select code has a defined tick.
    generate
        if (NSRC >= PAD) begin : g_full
            assign tick_vec = src_tick[PAD-1:0];
            if (NSRC > PAD) begin : g_extra
                logic unused_ticks;
                assign unused_ticks = ^src_tick[NSRC-1:PAD];
            end
        end else begin : g_pad
            assign tick_vec = {{(PAD-NSRC){1'b0}}, src_tick};
        end
    endgenerate

    assign tick_sel = tick_vec[sel_live];

    refclk_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .active    (active),
        .reg_rdata (reg_rdata),
        .sel_stage (sel_stage),
        .sel_live  (sel_live),
        .div_stage (div_stage),
        .div_live  (div_live),
        .trim_live (trim_live),
        .on_bit    (on_bit),
        .oe_bit    (oe_bit),
        .sw_pend   (sw_pend)
    );

    refclk_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (on_bit),
        .restart (sw_pend),
        .tick    (tick_sel),
        .div     (div_live),
        .trim    (trim_live),
        .clk_q   (gen_q),
        .busy    (active)
    );

    assign ref_out = gen_q && oe_bit;
endmodule

// File: rtl/refclk_frac_div_chk.sv
// Checker: temporal properties of the divider, bound into the top.
module refclk_frac_div_chk
    import refclk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             on_bit,
    input logic             sw_pend,
    input logic             active,
    input logic [SEL_W-1:0] sel_stage,
    input logic [DIV_W-1:0] div_stage,
    input logic [DIV_W-1:0] div_live,
    input logic             ref_out
);
    AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pend |=> !sw_pend); // R3
    AST_COMMIT_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pend |=> (div_live == $past(div_stage))); // R3
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !on_bit |=> !ref_out); // R8
    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(sel_stage)); // R9
    AST_ACTIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_bit) |=> active); // R9
endmodule

bind refclk_frac_div refclk_frac_div_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_bit    (on_bit),
    .sw_pend   (sw_pend),
    .active    (active),
    .sel_stage (sel_stage),
    .div_stage (div_stage),
    .div_live  (div_live),
    .ref_out   (ref_out)
);

// File: tb/test_refclk_frac_div.sv
module test_refclk_frac_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_tick = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ref_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    refclk_frac_div i_refclk_frac_div (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ref_out(ref_out)
    );

    always #5 clk = ~clk;

    function automatic int exp_half(int d, int t, int k);
        int n;
        if (k == 0) n = d;
        else n = d + (k * t) / 512 - ((k - 1) * t) / 512;
        if (n < 1) n = 1;
        return n;
    endfunction

    function automatic logic [31:0] ctrl_word(int sel, int d, bit on, bit oe, bit sw);
        logic [31:0] w;
        w = '0;
        w[3:0] = 4'(sel);
        w[30:16] = 15'(d);
        w[15] = on;
        w[12] = oe;
        w[9] = sw;
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 5'h00;
    endtask

    task automatic configure(int sel, int d, int t, bit oe);
        wr(5'h10, 32'(t) << 23);
        wr(5'h00, ctrl_word(sel, d, 1'b1, oe, 1'b1));
        check("R3 switch set", 32'(reg_rdata[9]), 32'd1);
        @(negedge clk);
        check("R3 switch cleared", 32'(reg_rdata[9]), 32'd0);
        check("R9 running flag", 32'(reg_rdata[8]), 32'd1);
    endtask

    task automatic stop_gen(int sel);
        wr(5'h00, ctrl_word(sel, 0, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        check("R9 running flag clear", 32'(reg_rdata[8]), 32'd0);
    endtask

    // Count ticks of the live source per half period, compare to closed form.
    task automatic run_ratio(string req, int sel, int d, int t, int nh);
        int cnt = 0;
        int k = 0;
        int guard = 0;
        logic prev = ref_out;
        logic last;
        src_tick = 16'($urandom);
        last = src_tick[sel];
        while (k < nh && guard < 20000) begin
            @(negedge clk);
            guard++;
            cnt += int'(last);
            if (ref_out !== prev) begin
                check(req, 32'(cnt), 32'(exp_half(d, t, k)));
                k++;
                cnt = 0;
                prev = ref_out;
            end
            src_tick = 16'($urandom);
            last = src_tick[sel];
        end
        if (k < nh) check({req, " halves seen"}, 32'(k), 32'(nh));
        src_tick = '0;
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_addr = 5'h00; #1;
        check("R1 ctrl reset", reg_rdata, 32'h0);
        reg_addr = 5'h10; #1;
        check("R1 trim reset", reg_rdata, 32'h0);
        check("R1 out reset", 32'(ref_out), 32'd0);
        reg_addr = 5'h00;

        // R2 field readback
        wr(5'h10, 32'd300 << 23);
        reg_addr = 5'h10; #1;
        check("R2 trim field", 32'(reg_rdata[31:23]), 32'd300);
        reg_addr = 5'h00;
        wr(5'h00, ctrl_word(5, 1234, 1'b0, 1'b1, 1'b0));
        check("R2 ctrl fields", reg_rdata, 32'h04D2_1005);

        // R5 directed: integer only, then heavy trim
        configure(2, 3, 0, 1'b1);
        run_ratio("R5 div3 trim0", 2, 3, 0, 8);
        // R4 staged divisor without switch keeps old period
        wr(5'h00, ctrl_word(2, 5, 1'b1, 1'b1, 1'b0));
        check("R4 staged readback", 32'(reg_rdata[30:16]), 32'd5);
        run_ratio("R4 unswitched div", 2, 3, 0, 6);
        // R9 source write ignored while running
        wr(5'h00, ctrl_word(7, 5, 1'b1, 1'b1, 1'b0));
        check("R9 source held", 32'(reg_rdata[3:0]), 32'd2);
        stop_gen(2);

        configure(9, 1, 511, 1'b1);
        run_ratio("R5 div1 trim511", 9, 1, 511, 12);
        stop_gen(9);
        configure(4, 2, 256, 1'b1);
        run_ratio("R5 div2 trim256", 4, 2, 256, 10);
        stop_gen(4);

        // R6 pass-through
        configure(3, 0, 0, 1'b1);
        for (int i = 0; i < 20; i++) begin
            logic last;
            src_tick = 16'($urandom);
            last = src_tick[3];
            @(negedge clk);
            check("R6 pass-through", 32'(ref_out), 32'(last));
        end
        src_tick = '0;
        stop_gen(3);

        // R8 pin enable clear keeps output low
        configure(1, 1, 0, 1'b0);
        for (int i = 0; i < 30; i++) begin
            src_tick = 16'hFFFF;
            @(negedge clk);
            check("R8 pin disabled", 32'(ref_out), 32'd0);
        end
        src_tick = '0;
        stop_gen(1);
        // R8 run clear: ticks cannot move output
        for (int i = 0; i < 10; i++) begin
            src_tick = 16'hFFFF;
            @(negedge clk);
            check("R8 run clear", 32'(ref_out), 32'd0);
        end
        src_tick = '0;

        // R7 random sources, divisors and trims
        for (int n = 0; n < 6; n++) begin
            int s = int'($urandom % 16);
            int d = 1 + int'($urandom % 5);
            int t = int'($urandom % 512);
            configure(s, d, t, 1'b1);
            run_ratio("R7 R5 random", s, d, t, 10);
            stop_gen(s);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule